// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block holds a small bank of ownership tokens that two independent processors, one on a left port and one on a right port, use to agree on which of them owns a shared resource. Each token is a flag. A processor asks for a flag by writing a zero to it. It learns whether it won by reading the flag back, and it gives the flag up by writing a one.

Each flag keeps one request latch per side and a record of which side owns it. A request that loses stays latched. When the owner releases the flag, the token moves to the waiting side at that same clock edge. When both sides ask for a free flag in the same cycle, a per-flag preference bit decides the winner, and that bit flips after every tie so that the two sides take turns. Read data is combinational from the registered state, so the result of a write is visible on a read in the cycle after the write.

Top module: `sem_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every flag is free. A read of any flag from either port returns 1.
- R2: A write with write-data 0 to a free flag gives that flag to the writing side. From the next cycle on, that side reads 0 and the other side reads 1.
- R3: A side that writes 0 to a flag held by the other side does not get the flag. It reads back 1, and the owner still reads 0.
- R4: When both sides write 0 to the same free flag in one cycle, exactly one side gets it. The first such tie on a flag after reset goes to the left side. Each later tie on that same flag goes to the side that lost the previous tie on it.
- R5: When the owner writes 1 to a flag while the other side has a latched request for it, the waiting side owns the flag from the next cycle and reads 0. The old owner reads 1.
- R6: An owner that writes 0 again to a flag it already holds keeps that flag.
- R7: A write of 1 from a side that neither holds the flag nor has a request pending on it leaves the owner unchanged.
- R8: The flags are independent. The 3-bit index selects one of eight flags, and an operation on one index leaves every other flag unchanged.
- R9: When a port is not reading (select low or read strobe low), its read data is 1.
- R10: A side that writes 1 while its request is pending withdraws that request. If the owner then releases, the flag becomes free. A release with no waiting side also leaves the flag free.
- R11: A write strobe with the select low has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel | input | 1 | Left port semaphore select |
| l_idx | input | 3 | Left port flag index |
| l_wr | input | 1 | Left port write strobe |
| l_rd | input | 1 | Left port read strobe |
| l_wdata | input | 1 | Left port write data (0 = request, 1 = release) |
| l_rdata | output | 1 | Left port read data (0 = left owns the flag) |
| r_sel | input | 1 | Right port semaphore select |
| r_idx | input | 3 | Right port flag index |
| r_wr | input | 1 | Right port write strobe |
| r_rd | input | 1 | Right port read strobe |
| r_wdata | input | 1 | Right port write data (0 = request, 1 = release) |
| r_rdata | output | 1 | Right port read data (0 = right owns the flag) |

## Verification
The hardest case to reach is a tie on a flag whose preference bit has already flipped. To get there, the same flag must go through a whole cycle first: a tie, a handoff to the waiting side, and a full release. Only then can the second tie on that flag be observed. The stimulus table walks flag 3 through exactly this sequence. It then uses the same flag to withdraw a pending request and checks that the owner's later release leaves the flag free. The table also parks an untouched token on flag 0 and reads it back between those steps, which confirms that the flags stay independent.

// File: rtl/sem_pkg.sv
// Package: shared types for the dual-port semaphore bank.
// Assumes nothing beyond two ports, named left and right.
package sem_pkg;

    // Who holds a flag at the moment
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } sem_owner_e;

    // Per-flag request command produced by one port decoder
    typedef struct packed {
        logic set;   // request latch set (write of 0)
        logic clr;   // request latch clear (write of 1)
    } sem_cmd_t;

endpackage

// File: rtl/sem_port_decode.sv
// Module: sem_port_decode
// Turns one port's select, index, write strobe and write bit into a
// one-hot set/clear command for each flag.
// Assumes at most one flag is addressed per cycle per port.
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W = $clog2(NUM_FLAGS)
) (
    input  logic             sel,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr,
    input  logic             wdata,
    output sem_cmd_t         cmd [NUM_FLAGS]
);

    logic write_en;

    // Purpose: qualify the write strobe with the port select
    always_comb begin
        write_en = sel && wr;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_dec
        // Purpose: produce the command for flag g when it is addressed
        always_comb begin
            cmd[g].set = write_en && (idx == IDX_W'(g)) && !wdata;
            cmd[g].clr = write_en && (idx == IDX_W'(g)) &&  wdata;
        end
    end

endmodule

// File: rtl/sem_flag_cell.sv
// Module: sem_flag_cell
// One semaphore flag: a request latch per side, the owner record, and a
// tie preference bit that flips after every simultaneous request.
// Assumes the commands from each side are already decoded and qualified.
module sem_flag_cell
    import sem_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sem_cmd_t l_cmd,
    input  sem_cmd_t r_cmd,
    output logic     grant_l,
    output logic     grant_r
);

    logic       req_l_q, req_r_q;
    logic       req_l_d, req_r_d;
    sem_owner_e owner_q, owner_d;
    logic       pref_r_q, pref_r_d;   // 0: left wins next tie, 1: right wins

    // Purpose: next value of each side's request latch
    always_comb begin
        req_l_d = req_l_q;
        if (l_cmd.set)      req_l_d = 1'b1;
        else if (l_cmd.clr) req_l_d = 1'b0;
        req_r_d = req_r_q;
        if (r_cmd.set)      req_r_d = 1'b1;
        else if (r_cmd.clr) req_r_d = 1'b0;
    end

    // Purpose: hand the token over based on the updated requests
    always_comb begin
        owner_d  = owner_q;
        pref_r_d = pref_r_q;
        unique case (owner_q)
            OWN_LEFT: begin
                if (!req_l_d) owner_d = req_r_d ? OWN_RIGHT : OWN_NONE;
            end
            OWN_RIGHT: begin
                if (!req_r_d) owner_d = req_l_d ? OWN_LEFT : OWN_NONE;
            end
            default: begin
                if (req_l_d && req_r_d) begin
                    owner_d  = pref_r_q ? OWN_RIGHT : OWN_LEFT;
                    pref_r_d = !pref_r_q;
                end else if (req_l_d) begin
                    owner_d = OWN_LEFT;
                end else if (req_r_d) begin
                    owner_d = OWN_RIGHT;
                end else begin
                    owner_d = OWN_NONE;
                end
            end
        endcase
    end

    // Purpose: state registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_l_q  <= 1'b0;
            req_r_q  <= 1'b0;
            owner_q  <= OWN_NONE;
            pref_r_q <= 1'b0;
        end else begin
            req_l_q  <= req_l_d;
            req_r_q  <= req_r_d;
            owner_q  <= owner_d;
            pref_r_q <= pref_r_d;
        end
    end

    // Purpose: present the ownership to the read path
    always_comb begin
        grant_l = (owner_q == OWN_LEFT);
        grant_r = (owner_q == OWN_RIGHT);
    end

endmodule

// File: rtl/sem_read_mux.sv
// Module: sem_read_mux
// Returns 0 when the port reads a flag it owns, and 1 in every other case,
// including when no read is in progress.
// Assumes the grant vector is the registered ownership for this port.
module sem_read_mux #(
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W = $clog2(NUM_FLAGS)
) (
    input  logic [NUM_FLAGS-1:0] grant,
    input  logic                 sel,
    input  logic                 rd,
    input  logic [IDX_W-1:0]     idx,
    output logic                 rdata
);

    // Purpose: select the addressed flag and invert it into read data
    always_comb begin
        rdata = 1'b1;
        if (sel && rd) rdata = !grant[idx];
    end

endmodule

// File: rtl/sem_bank.sv
// Module: sem_bank (top)
// Bank of NUM_FLAGS semaphore flags shared by a left and a right port.
// Assumes the two ports are synchronous to clk. The reset exists only so
// that the bank can be driven into a known state.
module sem_bank
    import sem_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    localparam int IDX_W = $clog2(NUM_FLAGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             l_sel,
    input  logic [IDX_W-1:0] l_idx,
    input  logic             l_wr,
    input  logic             l_rd,
    input  logic             l_wdata,
    output logic             l_rdata,
    input  logic             r_sel,
    input  logic [IDX_W-1:0] r_idx,
    input  logic             r_wr,
    input  logic             r_rd,
    input  logic             r_wdata,
    output logic             r_rdata
);

    sem_cmd_t             l_cmd [NUM_FLAGS];
    sem_cmd_t             r_cmd [NUM_FLAGS];
    logic [NUM_FLAGS-1:0] grant_l;
    logic [NUM_FLAGS-1:0] grant_r;

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_l (
        .sel(l_sel), .idx(l_idx), .wr(l_wr), .wdata(l_wdata), .cmd(l_cmd)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS)) u_dec_r (
        .sel(r_sel), .idx(r_idx), .wr(r_wr), .wdata(r_wdata), .cmd(r_cmd)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        sem_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .l_cmd   (l_cmd[g]),
            .r_cmd   (r_cmd[g]),
            .grant_l (grant_l[g]),
            .grant_r (grant_r[g])
        );
    end

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS)) u_rd_l (
        .grant(grant_l), .sel(l_sel), .rd(l_rd), .idx(l_idx), .rdata(l_rdata)
    );

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS)) u_rd_r (
        .grant(grant_r), .sel(r_sel), .rd(r_rd), .idx(r_idx), .rdata(r_rdata)
    );

endmodule

// File: rtl/sem_bank_chk.sv
// Module: sem_bank_chk
// Temporal checks on the ownership vectors of sem_bank, attached by bind.
// Assumes grant_l and grant_r are the per-flag ownership outputs.
module sem_bank_chk #(
    parameter int NUM_FLAGS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_sel,
    input logic                 l_wr,
    input logic                 r_sel,
    input logic                 r_wr,
    input logic [NUM_FLAGS-1:0] grant_l,
    input logic [NUM_FLAGS-1:0] grant_r
);

    AST_NO_DOUBLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_l & grant_r) == '0);  // R4

    AST_RESET_FREES_ALL: assert property (@(posedge clk)
        !rst_n |=> (grant_l == '0 && grant_r == '0));  // R1

    AST_LEFT_KEEPS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_sel && l_wr) |=> (($past(grant_l) & ~grant_l) == '0));  // R6

    AST_RIGHT_KEEPS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_sel && r_wr) |=> (($past(grant_r) & ~grant_r) == '0));  // R6

    AST_NO_STEAL_FROM_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_sel && r_wr) |=> (($past(grant_r) & grant_l) == '0));  // R3

endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS)) u_sem_bank_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .l_sel   (l_sel),
    .l_wr    (l_wr),
    .r_sel   (r_sel),
    .r_wr    (r_wr),
    .grant_l (grant_l),
    .grant_r (grant_r)
);

// File: tb/test_sem_bank.sv
module test_sem_bank;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       l_sel, l_wr, l_rd, l_wdata;
    logic [2:0] l_idx;
    logic       r_sel, r_wr, r_rd, r_wdata;
    logic [2:0] r_idx;
    logic       l_rdata, r_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    sem_bank i_sem_bank (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_idx(l_idx), .l_wr(l_wr), .l_rd(l_rd),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_idx(r_idx), .r_wr(r_wr), .r_rd(r_rd),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    // op codes: 0 none, 1 write 0 (request), 2 write 1 (release)
    // vector: {l_op[2], l_idx[3], r_op[2], r_idx[3], chk_idx[3], exp_l, exp_r}
    localparam int NV = 13;
    localparam logic [14:0] VEC [NV] = '{
        {2'd1, 3'd0, 2'd0, 3'd0, 3'd0, 1'b0, 1'b1},  // R2 left claims f0
        {2'd0, 3'd0, 2'd1, 3'd0, 3'd0, 1'b0, 1'b1},  // R3 right blocked
        {2'd2, 3'd0, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0},  // R5 handoff to right
        {2'd0, 3'd0, 2'd1, 3'd0, 3'd0, 1'b1, 1'b0},  // R6 re-request keeps
        {2'd2, 3'd0, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0},  // R7 stray release
        {2'd1, 3'd3, 2'd1, 3'd3, 3'd3, 1'b0, 1'b1},  // R4 first tie -> left
        {2'd0, 3'd0, 2'd0, 3'd0, 3'd0, 1'b1, 1'b0},  // R8 f0 untouched
        {2'd2, 3'd3, 2'd0, 3'd0, 3'd3, 1'b1, 1'b0},  // R5 f3 to right
        {2'd0, 3'd0, 2'd2, 3'd3, 3'd3, 1'b1, 1'b1},  // R10 release, none waiting
        {2'd1, 3'd3, 2'd1, 3'd3, 3'd3, 1'b1, 1'b0},  // R4 second tie -> right
        {2'd2, 3'd3, 2'd0, 3'd0, 3'd3, 1'b1, 1'b0},  // R10 left withdraws
        {2'd0, 3'd0, 2'd2, 3'd3, 3'd3, 1'b1, 1'b1},  // R10 flag free after release
        {2'd0, 3'd0, 2'd2, 3'd0, 3'd0, 1'b1, 1'b1}   // R8 f0 released
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        l_sel = 0; l_wr = 0; l_rd = 0; l_wdata = 0; l_idx = '0;
        r_sel = 0; r_wr = 0; r_rd = 0; r_wdata = 0; r_idx = '0;
    endtask

    // one write cycle on both ports, applied at the falling edge
    task automatic do_writes(input logic [1:0] lop, input logic [2:0] li,
                             input logic [1:0] rop, input logic [2:0] ri);
        @(negedge clk);
        idle_inputs();
        l_sel = (lop != 0); l_wr = (lop != 0); l_wdata = (lop == 2); l_idx = li;
        r_sel = (rop != 0); r_wr = (rop != 0); r_wdata = (rop == 2); r_idx = ri;
        @(negedge clk);
        idle_inputs();
    endtask

    // combinational read of one flag from both ports, between edges
    task automatic read_both(input logic [2:0] idx, output logic lv, output logic rv);
        l_sel = 1; l_rd = 1; l_idx = idx;
        r_sel = 1; r_rd = 1; r_idx = idx;
        #1;
        lv = l_rdata; rv = r_rdata;
        idle_inputs();
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic lv, rv;
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state: every flag free from both sides
        for (int i = 0; i < 8; i++) begin
            read_both(3'(i), lv, rv);
            check("R1 left", lv, 1'b1);
            check("R1 right", rv, 1'b1);
        end

        // table walk
        for (int v = 0; v < NV; v++) begin
            do_writes(VEC[v][14:13], VEC[v][12:10], VEC[v][9:8], VEC[v][7:5]);
            read_both(VEC[v][4:2], lv, rv);
            check($sformatf("vec %0d left (R2-R10 table)", v), lv, VEC[v][1]);
            check($sformatf("vec %0d right (R2-R10 table)", v), rv, VEC[v][0]);
        end

        // R11: write strobe with select low has no effect
        @(negedge clk);
        r_sel = 0; r_wr = 1; r_wdata = 0; r_idx = 3'd6;
        @(negedge clk); idle_inputs();
        read_both(3'd6, lv, rv);
        check("R11 right", rv, 1'b1);
        check("R11 left", lv, 1'b1);

        // R9: idle read returns 1 even while the port owns the flag
        do_writes(2'd1, 3'd7, 2'd0, 3'd0);
        l_sel = 1; l_rd = 0; l_idx = 3'd7; #1;
        check("R9 rd low", l_rdata, 1'b1);
        l_sel = 0; l_rd = 1; #1;
        check("R9 sel low", l_rdata, 1'b1);
        idle_inputs();
        read_both(3'd7, lv, rv);
        check("R2 left owns f7", lv, 1'b0);

        // R1: reset mid-run frees the held flag
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        read_both(3'd7, lv, rv);
        check("R1 after reset left", lv, 1'b1);
        check("R1 after reset right", rv, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule